// File: doc/BRIEF.md
# Multi-channel edge capture timer

The block timestamps edges on up to four external inputs. A free-running counter advances once per prescaled tick of the input clock. Each channel watches its own input for the edge its mode selects. On a match it copies the counter into that channel's capture register and raises that channel's pending flag.

A simple register port controls the block. It offers a run bit, a prescale field, per-channel edge modes, per-channel interrupt enables, a pending-flag register and an acknowledge register that clears flags when 1s are written to it. Software turns the captured timestamps into period and duty. It may change a channel's edge mode right after a capture, for example from rising to falling, to catch the opposite edge of the same pulse.

Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. Unmapped addresses read as zero.

Top module: `cap_timer`

## Requirements
- R1: After reset the control, enable and pending registers read 0, every capture register reads 0 and `irq` is low.
- R2: Edge mode code 1 captures only a 0-to-1 transition of the channel input. A 1-to-0 transition sets no flag and leaves the capture register unchanged.
- R3: Edge mode code 2 captures only a 1-to-0 transition. A 0-to-1 transition sets no flag.
- R4: Edge mode code 3 captures both transitions.
- R5: Edge mode code 0 captures nothing: no flag is set and the capture register keeps its value.
- R6: An input change made between clock edges passes two synchronizer flops and one history flop. The flag and the capture register update on the third rising clock edge after the change. The register holds the counter value from just before that edge.
- R7: With prescale field P (control bits 8:4), the counter advances by exactly 1 every P+1 clocks while running. The difference between two captures equals the elapsed clocks divided by P+1.
- R8: While the run bit (control bit 10) is 0, the counter is held at 0 and no channel captures. After a write sets the run bit, the counter reads 1 and 2 on the following two clocks.
- R9: A new edge mode written after a capture applies to the next edge of that channel.
- R10: Channel n's pending flag is bit n+1 of offset 0x58. Writing offset 0x5C clears each flag whose bit (n+1) is 1 in the written data. Bit 0, bits 8:5 and bits written as 0 have no effect. Writing 0x1FF clears all flags.
- R11: A flag set by a capture on the same clock edge as an acknowledge of that flag stays set.
- R12: `irq` is high exactly when some channel has both its pending flag and its enable set. Channel n's enable is bit n+1 of offset 0x54.
- R13: Capture register n reads at 0x10+4n. The edge mode of channel n reads and writes at 0x30+4n, bits 1:0, and other bits read 0. The control register at 0x50 keeps only bits 8:4 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic and for counting |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr` |
| cap_in | input | NCH (4) | Asynchronous capture inputs |
| irq | output | 1 | Enabled pending flags, ORed |

## Verification
Each timing scenario pins the capture latency to the cycle. A synchronizer stage too few or too many shows up at once as a flag that appears one read early or late. It also shows as a captured value off by one from the expected 2 after run is set. A counter that is not cleared while stopped, or a prescaler that miscounts, shows in the first capture after restart or in the difference of two timestamps taken a fixed number of clocks apart. Wrong edge-mode or flag-merge state shows within four clocks as a missing or extra flag bit, or as an `irq` level that does not match the enabled flags.

// File: rtl/cap_pkg.sv
// Shared definitions for the edge capture timer: edge mode codes and the
// register offsets and bit positions that software decodes.
package cap_pkg;
    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_t;

    localparam int VAL_BASE = 'h10;
    localparam int SEL_BASE = 'h30;
    localparam int CTRL_OFS = 'h50;
    localparam int IE_OFS   = 'h54;
    localparam int ST_OFS   = 'h58;
    localparam int ACK_OFS  = 'h5C;
    localparam int RUN_BIT  = 10;
    localparam int PS_LSB   = 4;
    localparam int FLAG_LSB = 1;
    localparam int MAX_CH   = 4;
endpackage

// File: rtl/cap_tick_counter.sv
// Prescaled free-running timestamp counter.
// While run is high it advances by one every (prescale+1) clocks; while run is
// low both the divider and the counter are held at zero.
// Assumes run and prescale come from registers in the same clock domain.
module cap_tick_counter #(
    parameter int PS_W  = 5,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PS_W-1:0]  prescale,
    output logic [CNT_W-1:0] count
);
    logic [PS_W-1:0] div_q;
    logic            tick;

    // A tick ends each divider period
    assign tick = run && (div_q >= prescale);

    // Divider: counts clocks within one prescaled period
    always_ff @(posedge clk) begin
        if (!rst_n)            div_q <= '0;
        else if (!run || tick) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

    // Timestamp counter: cleared while stopped, advanced on each tick
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (!run) count <= '0;
        else if (tick) count <= count + 1'b1;
    end

    // R8: stopped for two edges means the counter reads zero
    a_r8_held_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $past(!run)) |-> (count == '0));

    // R7: while running, the counter only ever steps by one
    a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && run && (count != $past(count)))
            |-> (count == $past(count) + CNT_W'(1)));
endmodule

// File: rtl/cap_lane.sv
// One capture channel: two-flop synchronizer, a history flop for edge
// detection, mode-selected edge match and the capture register.
// Assumes pin is asynchronous to clk and count is already synchronous.
module cap_lane
    import cap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  edge_mode_t       sel,
    input  logic             pin,
    input  logic [CNT_W-1:0] count,
    output logic             hit,
    output logic [CNT_W-1:0] value
);
    logic [2:0] sync_q;
    logic       rise;
    logic       fall;

    // Synchronize the pin (bits 0,1) and keep one cycle of history (bit 2)
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], pin};
    end

    assign rise = sync_q[1] && !sync_q[2];
    assign fall = !sync_q[1] && sync_q[2];

    // Match the detected transition against the channel's edge mode
    always_comb begin
        unique case (sel)
            EDGE_RISE: hit = run && rise;
            EDGE_FALL: hit = run && fall;
            EDGE_BOTH: hit = run && (rise || fall);
            default:   hit = 1'b0;
        endcase
    end

    // Capture register: takes the timestamp on a matched edge
    always_ff @(posedge clk) begin
        if (!rst_n)   value <= '0;
        else if (hit) value <= count;
    end

    // R6: a match stores the counter value seen in that cycle
    a_r6_value_latched: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hit) |-> (value == $past(count)));

    // R5: with edge mode off the capture register does not move
    a_r5_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EDGE_NONE) |=> $stable(value));
endmodule

// File: rtl/cap_regfile.sv
// Register port of the capture timer: control (run, prescale), per-channel
// edge modes, interrupt enables, pending flags with write-1 acknowledge,
// the read mux and the interrupt line.
// Assumes single-cycle writes and combinational reads; flags sit at bit n+1.
module cap_regfile
    import cap_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 32,
    parameter int PS_W   = 5,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NCH-1:0]       hit,
    input  logic [NCH*CNT_W-1:0] cap_flat,
    output logic [2*NCH-1:0]     sel_flat,
    output logic                 run,
    output logic [PS_W-1:0]      prescale,
    output logic                 irq
);
    logic [NCH-1:0] ie_q;
    logic [NCH-1:0] st_q;
    logic [NCH-1:0] ack_mask;
    logic           wr_ctrl;
    logic           wr_ie;
    logic           wr_ack;
    logic           unused_wdata;

    assign unused_wdata = ^bus_wdata;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));
    assign wr_ie   = bus_wr && (bus_addr == ADDR_W'(IE_OFS));
    assign wr_ack  = bus_wr && (bus_addr == ADDR_W'(ACK_OFS));
    assign ack_mask = wr_ack ? bus_wdata[FLAG_LSB +: NCH] : '0;

    // Control register: run bit and capture prescale
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            prescale <= '0;
        end else if (wr_ctrl) begin
            run      <= bus_wdata[RUN_BIT];
            prescale <= bus_wdata[PS_LSB +: PS_W];
        end
    end

    // Interrupt enable register
    always_ff @(posedge clk) begin
        if (!rst_n)     ie_q <= '0;
        else if (wr_ie) ie_q <= bus_wdata[FLAG_LSB +: NCH];
    end

    // Pending flags: acknowledge clears, a new capture sets and wins
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~ack_mask) | hit;
    end

    assign irq = |(st_q & ie_q);

    for (genvar n = 0; n < NCH; n++) begin : g_sel
        // Edge mode register of channel n
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_flat[2*n +: 2] <= 2'b00;
            else if (bus_wr && (bus_addr == ADDR_W'(SEL_BASE + 4*n)))
                sel_flat[2*n +: 2] <= bus_wdata[1:0];
        end

        // R11: a capture always leaves its flag set on the next cycle
        a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            $past(hit[n]) |-> st_q[n]);

        // R10: an acknowledge without a new capture clears the flag
        a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            $past(wr_ack && bus_wdata[FLAG_LSB + n] && !hit[n]) |-> !st_q[n]);
    end

    // Read mux by byte address; unmapped addresses return zero
    always_comb begin
        bus_rdata = '0;
        for (int n = 0; n < NCH; n++) begin
            if (bus_addr == ADDR_W'(VAL_BASE + 4*n))
                bus_rdata = DATA_W'(cap_flat[n*CNT_W +: CNT_W]);
            if (bus_addr == ADDR_W'(SEL_BASE + 4*n))
                bus_rdata = DATA_W'(sel_flat[2*n +: 2]);
        end
        if (bus_addr == ADDR_W'(CTRL_OFS)) begin
            bus_rdata[RUN_BIT]          = run;
            bus_rdata[PS_LSB +: PS_W]   = prescale;
        end
        if (bus_addr == ADDR_W'(IE_OFS)) bus_rdata[FLAG_LSB +: NCH] = ie_q;
        if (bus_addr == ADDR_W'(ST_OFS)) bus_rdata[FLAG_LSB +: NCH] = st_q;
    end
endmodule

// File: rtl/cap_timer.sv
// Top of the edge capture timer: one prescaled timestamp counter shared by
// NCH capture lanes, with the register port and interrupt line.
// Assumes NCH <= 4 so that the flags fit in bits 4:1, and CNT_W <= DATA_W.
module cap_timer
    import cap_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 32,
    parameter int PS_W   = 5,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    cap_in,
    output logic              irq
);
    logic                 run;
    logic [PS_W-1:0]      prescale;
    logic [CNT_W-1:0]     count;
    logic [NCH-1:0]       hit;
    logic [NCH*CNT_W-1:0] cap_flat;
    logic [2*NCH-1:0]     sel_flat;

    initial begin
        if (NCH > MAX_CH || NCH < 1) $error("cap_timer: NCH out of range");
    end

    cap_tick_counter #(.PS_W(PS_W), .CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .prescale (prescale),
        .count    (count)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_lane
        cap_lane #(.CNT_W(CNT_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .sel   (edge_mode_t'(sel_flat[2*n +: 2])),
            .pin   (cap_in[n]),
            .count (count),
            .hit   (hit[n]),
            .value (cap_flat[n*CNT_W +: CNT_W])
        );
    end

    cap_regfile #(
        .NCH(NCH), .CNT_W(CNT_W), .PS_W(PS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hit       (hit),
        .cap_flat  (cap_flat),
        .sel_flat  (sel_flat),
        .run       (run),
        .prescale  (prescale),
        .irq       (irq)
    );
endmodule

// File: tb/test_cap_timer.sv
// Directed bench for cap_timer: one task per scenario, inputs driven just
// after the falling clock edge, outputs sampled 1 ns later.
module test_cap_timer;
    localparam logic [7:0] A_CTRL = 8'h50;
    localparam logic [7:0] A_IE   = 8'h54;
    localparam logic [7:0] A_ST   = 8'h58;
    localparam logic [7:0] A_ACK  = 8'h5C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  cap_in = '0;
    logic        irq;

    int nvec = 0;
    int nbad = 0;

    always #10 clk = ~clk;

    cap_timer i_cap_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in), .irq(irq)
    );

    function automatic logic [7:0] a_val(input int n);
        return 8'(8'h10 + 4*n);
    endfunction
    function automatic logic [7:0] a_sel(input int n);
        return 8'(8'h30 + 4*n);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(tag, d, exp);
    endtask

    task automatic t_reset();
        expect_reg("R1 ctrl", A_CTRL, 32'h0);
        expect_reg("R1 status", A_ST, 32'h0);
        expect_reg("R1 enable", A_IE, 32'h0);
        for (int n = 0; n < 4; n++) expect_reg("R1 capture", a_val(n), 32'h0);
        #1 check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_regmap();
        wr(a_sel(2), 32'h3);
        expect_reg("R13 sel readback", a_sel(2), 32'h3);
        wr(a_sel(2), 32'hFFFF_FFFC);
        expect_reg("R13 sel two bits", a_sel(2), 32'h0);
        wr(A_CTRL, 32'hFFFF_FFFF);
        expect_reg("R13 ctrl fields", A_CTRL, 32'h0000_05F0);
        wr(A_CTRL, 32'h0);
        wr(A_IE, 32'hFFFF_FFFF);
        expect_reg("R13 enable bits", A_IE, 32'h0000_001E);
        wr(A_IE, 32'h0);
    endtask

    task automatic t_latency();
        wr(a_sel(0), 32'h1);
        wr(A_CTRL, 32'h400);
        cap_in[0] = 1'b1;
        step(1);
        expect_reg("R6 flag after 1 edge", A_ST, 32'h0);
        step(1);
        expect_reg("R6 flag after 2 edges", A_ST, 32'h0);
        step(1);
        expect_reg("R6 flag after 3 edges", A_ST, 32'h2);
        expect_reg("R6 R8 value after start", a_val(0), 32'h2);
        step(30);
        wr(A_CTRL, 32'h0);
        step(5);
        wr(a_sel(1), 32'h1);
        wr(A_CTRL, 32'h400);
        cap_in[1] = 1'b1;
        step(3);
        expect_reg("R8 restart from zero", a_val(1), 32'h2);
        expect_reg("R6 two flags", A_ST, 32'h6);
        wr(A_ACK, 32'h1FF);
        expect_reg("R10 clear all", A_ST, 32'h0);
    endtask

    task automatic t_stopped();
        wr(A_CTRL, 32'h0);
        wr(a_sel(2), 32'h3);
        cap_in[2] = 1'b1;
        step(4);
        cap_in[2] = 1'b0;
        step(4);
        expect_reg("R8 no flag while stopped", A_ST, 32'h0);
        expect_reg("R8 no capture while stopped", a_val(2), 32'h0);
    endtask

    task automatic t_rise_fall();
        wr(A_CTRL, 32'h400);
        cap_in[0] = 1'b0;
        step(4);
        expect_reg("R2 fall ignored flag", A_ST, 32'h0);
        expect_reg("R2 fall ignored value", a_val(0), 32'h2);
        cap_in[0] = 1'b1;
        step(4);
        expect_reg("R2 rise captured", A_ST, 32'h2);
        wr(A_ACK, 32'h1FF);
        wr(a_sel(3), 32'h2);
        cap_in[3] = 1'b1;
        step(4);
        expect_reg("R3 rise ignored", A_ST, 32'h0);
        cap_in[3] = 1'b0;
        step(4);
        expect_reg("R3 fall captured", A_ST, 32'h10);
        wr(A_ACK, 32'h1FF);
    endtask

    task automatic t_both_and_rate();
        logic [31:0] va, vb;
        cap_in[2] = 1'b1;
        step(4);
        expect_reg("R4 rise in both mode", A_ST, 32'h8);
        rd(a_val(2), va);
        wr(A_ACK, 32'h1FF);
        step(35);
        cap_in[2] = 1'b0;
        step(4);
        expect_reg("R4 fall in both mode", A_ST, 32'h8);
        rd(a_val(2), vb);
        check("R7 prescale 0 spacing", vb - va, 32'd40);
        wr(A_CTRL, 32'h430);
        wr(A_ACK, 32'h1FF);
        cap_in[2] = 1'b1;
        step(4);
        rd(a_val(2), va);
        step(36);
        cap_in[2] = 1'b0;
        step(4);
        rd(a_val(2), vb);
        check("R7 prescale 3 spacing", vb - va, 32'd10);
    endtask

    task automatic t_off_mode();
        wr(A_CTRL, 32'h400);
        wr(A_ACK, 32'h1FF);
        wr(a_sel(1), 32'h0);
        cap_in[1] = 1'b0;
        step(4);
        expect_reg("R5 no flag in off mode", A_ST, 32'h0);
        expect_reg("R5 value kept in off mode", a_val(1), 32'h2);
    endtask

    task automatic t_reprogram();
        logic [31:0] va, vb;
        wr(a_sel(3), 32'h1);
        cap_in[3] = 1'b1;
        step(4);
        expect_reg("R9 first edge", A_ST, 32'h10);
        rd(a_val(3), va);
        wr(a_sel(3), 32'h1 ^ 32'h3);
        wr(A_ACK, 32'h1FF);
        step(2);
        cap_in[3] = 1'b0;
        step(4);
        expect_reg("R9 new mode on next edge", A_ST, 32'h10);
        rd(a_val(3), vb);
        check("R9 spacing", vb - va, 32'd8);
        wr(A_ACK, 32'h1FF);
    endtask

    task automatic t_ack();
        wr(a_sel(0), 32'h3);
        cap_in[0] = 1'b0;
        cap_in[2] = 1'b1;
        step(4);
        expect_reg("R10 two flags", A_ST, 32'hA);
        wr(A_ACK, 32'h2);
        expect_reg("R10 partial ack", A_ST, 32'h8);
        wr(A_ACK, 32'h1E1);
        expect_reg("R10 unused ack bits", A_ST, 32'h8);
        wr(A_ACK, 32'h1FF);
        expect_reg("R10 full ack", A_ST, 32'h0);
    endtask

    task automatic t_collide();
        cap_in[2] = 1'b0;
        step(4);
        expect_reg("R11 setup flag", A_ST, 32'h8);
        cap_in[0] = 1'b1;
        step(2);
        wr(A_ACK, 32'h1FF);
        expect_reg("R11 set wins over ack", A_ST, 32'h2);
        wr(A_ACK, 32'h1FF);
        expect_reg("R11 later ack clears", A_ST, 32'h0);
    endtask

    task automatic t_irq();
        wr(A_IE, 32'h0);
        cap_in[0] = 1'b0;
        step(4);
        expect_reg("R12 flag present", A_ST, 32'h2);
        #1 check("R12 irq masked", {31'b0, irq}, 32'h0);
        wr(A_IE, 32'h4);
        #1 check("R12 other enable", {31'b0, irq}, 32'h0);
        wr(A_IE, 32'h2);
        #1 check("R12 irq raised", {31'b0, irq}, 32'h1);
        wr(A_ACK, 32'h2);
        #1 check("R12 irq after ack", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        #(20 * 150000);
        nbad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_regmap();
        t_latency();
        t_stopped();
        t_rise_fall();
        t_both_and_rate();
        t_off_mode();
        t_reprogram();
        t_ack();
        t_collide();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule